// File: doc/BRIEF.md
# Cache tag parity error handler

This block watches the tag words that two load pipes read from a data cache and checks each one against its stored parity bit. When a pipe reads a tag whose parity does not hold and checking is switched on, the block records the event. It sets a sticky status bit that belongs to that pipe and keeps the virtual address of the faulting reference. It also flags the event as uncorrectable when the load was a retry, because the instruction address is gone by then.

A machine-check request comes out of the block when machine-check reporting is enabled. The request is held pending while the processor runs in privileged mode. It is presented as soon as that mode is left and clears once it has been presented for one cycle. Software clears the recorded state with write-one-to-clear strobes. It can also turn parity checking off, which lets the faulting line be evicted without raising the error again.

Top module: `tag_parity_guard`

## Requirements
- R1: A pipe reports a parity error only in a cycle where its valid strobe is 1, the check enable is 1, and the XOR of all tag bits together with the parity bit is 1. The parity is even, so odd is an error. A pipe whose valid strobe is 0 has no effect.
- R2: While the check enable is 0, no status bit, address capture, uncorrectable flag or machine-check request comes from any tag read.
- R3: Status bit i (bit 0 = pipe 0, bit 1 = pipe 1) is set on the clock edge after a parity error on pipe i, and only on such an error. It stays set until a 1 is written to bit i of the status clear strobe. If a set and a clear arrive in the same cycle, the set wins.
- R4: On the edge after an error, if both status bits were clear, the address register takes the virtual address of the faulting pipe. When both pipes fail in the same cycle, the address of pipe 0 is taken and both status bits are set.
- R5: The address register is not overwritten while either status bit is set. A 1 on the address clear strobe sets it to zero when no capture happens in that cycle.
- R6: The uncorrectable flag is set on the edge after a parity error on a load whose retry flag is 1. An error without the retry flag leaves the flag unchanged. The address clear strobe clears it.
- R7: A parity error makes a machine check pending only when the machine-check enable is 1 in that cycle.
- R8: The machine-check request output equals "pending and not privileged". Pending stays set while privileged mode is 1, and it clears on the edge after a cycle in which the request was 1, unless a new enabled error arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chk_en | input | 1 | Tag parity check enable |
| mchk_en | input | 1 | Machine-check reporting enable |
| priv_mode | input | 1 | Processor is in privileged mode |
| pipe_vld | input | 2 | Tag read valid, one bit per pipe |
| pipe_retry | input | 2 | Read comes from a retried load, per pipe |
| pipe_tag | input | 2×TAG_W | Tag word read, per pipe |
| pipe_par | input | 2 | Stored parity bit, per pipe |
| pipe_va | input | 2×VA_W | Virtual address of the reference, per pipe |
| clr_stat | input | 2 | Write-one-to-clear strobe for the status bits |
| clr_va | input | 1 | Write-one-to-clear strobe for the address and uncorrectable flag |
| err_stat | output | 2 | Sticky parity error status, one per pipe |
| err_va | output | VA_W | Captured faulting virtual address |
| err_uncorr | output | 1 | Error is uncorrectable (retried load) |
| mchk_req | output | 1 | Machine-check request |

## Verification
Every tag and parity combination of a narrow 4-bit configuration is swept on each pipe alone. The retry flag and the machine-check enable are toggled across the sweep. This separates a good read from a bad one and pipe 0 from pipe 1, and it shows whether the uncorrectable flag and the request follow their own enables. Directed patterns then cover failures on both pipes at once, which tests the address priority. They also cover a second failure while the address is locked, a partial clear and a set that collides with a clear. A failure with checking disabled and a request held across several privileged cycles are tried as well, which tests the gating and the release timing.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int NUM_PIPES = 2;
    localparam int PAR_MAX_W = 128;

    typedef struct packed {
        logic err;
        logic uncorr;
    } pipe_res_t;

    function automatic logic parity_odd(input logic [PAR_MAX_W-1:0] bits);
        return ^bits;
    endfunction

endpackage

// File: rtl/tpg_pipe_check.sv
module tpg_pipe_check
    import tpg_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic             vld,
    input  logic             retry,
    input  logic             chk_en,
    input  logic [TAG_W-1:0] tag,
    input  logic             par,
    output pipe_res_t        res
);
    localparam int WORD_W = TAG_W + 1;

    logic [PAR_MAX_W-1:0] word_ext;
    logic                 bad;

    always_comb begin
        word_ext = '0;
        word_ext[WORD_W-1:0] = {par, tag};
        bad = parity_odd(word_ext);
        res.err    = vld & chk_en & bad;
        res.uncorr = vld & chk_en & bad & retry;
    end

    // R1 / R2: no error is reported without a valid, enabled read
    always_comb begin
        a_r2_gate: assert (!(res.err && !(vld && chk_en)));
    end

endmodule

// File: rtl/tpg_status.sv
module tpg_status
    import tpg_pkg::*;
#(
    parameter int VA_W = 44
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PIPES-1:0]           err,
    input  logic [NUM_PIPES-1:0]           uncorr,
    input  logic [NUM_PIPES-1:0][VA_W-1:0] va,
    input  logic [NUM_PIPES-1:0]           clr_stat,
    input  logic                           clr_va,
    output logic [NUM_PIPES-1:0]           stat_q,
    output logic [VA_W-1:0]                va_q,
    output logic                           uncorr_q
);
    logic [VA_W-1:0] cap_va;
    logic            any_new;
    logic            locked;

    always_comb begin
        cap_va = '0;
        for (int i = NUM_PIPES - 1; i >= 0; i--) begin
            if (err[i]) cap_va = va[i];
        end
        any_new = |err;
        locked  = |stat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q   <= '0;
            va_q     <= '0;
            uncorr_q <= 1'b0;
        end else begin
            stat_q <= (stat_q & ~clr_stat) | err;
            if (any_new && !locked)
                va_q <= cap_va;
            else if (clr_va)
                va_q <= '0;
            if (|uncorr)
                uncorr_q <= 1'b1;
            else if (clr_va)
                uncorr_q <= 1'b0;
        end
    end

    generate
        for (genvar g = 0; g < NUM_PIPES; g++) begin : g_stat_chk
            // R3: a status bit rises only from its own pipe
            a_r3_own_pipe: assert property (@(posedge clk) disable iff (rst)
                $rose(stat_q[g]) |-> $past(err[g]));
            // R3: set has priority over clear
            a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
                err[g] |=> stat_q[g]);
        end
    endgenerate

    // R5: address frozen while locked unless cleared
    a_r5_va_locked: assert property (@(posedge clk) disable iff (rst)
        (locked && !clr_va) |=> $stable(va_q));
    // R6: uncorrectable flag rises only on a retried error
    a_r6_uncorr_src: assert property (@(posedge clk) disable iff (rst)
        $rose(uncorr_q) |-> $past(|uncorr));

endmodule

// File: rtl/tpg_mchk.sv
module tpg_mchk (
    input  logic clk,
    input  logic rst,
    input  logic new_err,
    input  logic mchk_en,
    input  logic priv_mode,
    output logic req
);
    logic pend_q;

    assign req = pend_q & ~priv_mode;

    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b0;
        else
            pend_q <= (pend_q & ~req) | (new_err & mchk_en);
    end

    // R7: pending only from an enabled error
    a_r7_enabled_only: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(new_err && mchk_en));
    // R8: held while privileged
    a_r8_hold_priv: assert property (@(posedge clk) disable iff (rst)
        (pend_q && priv_mode) |=> pend_q);
    // R8: no request in privileged mode
    a_r8_no_req_priv: assert property (@(posedge clk) disable iff (rst)
        priv_mode |-> !req);

endmodule

// File: rtl/tag_parity_guard.sv
module tag_parity_guard
    import tpg_pkg::*;
#(
    parameter int TAG_W = 20,
    parameter int VA_W  = 44
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           chk_en,
    input  logic                           mchk_en,
    input  logic                           priv_mode,
    input  logic [NUM_PIPES-1:0]           pipe_vld,
    input  logic [NUM_PIPES-1:0]           pipe_retry,
    input  logic [NUM_PIPES-1:0][TAG_W-1:0] pipe_tag,
    input  logic [NUM_PIPES-1:0]           pipe_par,
    input  logic [NUM_PIPES-1:0][VA_W-1:0] pipe_va,
    input  logic [NUM_PIPES-1:0]           clr_stat,
    input  logic                           clr_va,
    output logic [NUM_PIPES-1:0]           err_stat,
    output logic [VA_W-1:0]                err_va,
    output logic                           err_uncorr,
    output logic                           mchk_req
);
    pipe_res_t            res [NUM_PIPES];
    logic [NUM_PIPES-1:0] err_v;
    logic [NUM_PIPES-1:0] unc_v;

    generate
        for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
            tpg_pipe_check #(.TAG_W(TAG_W)) u_chk (
                .vld    (pipe_vld[p]),
                .retry  (pipe_retry[p]),
                .chk_en (chk_en),
                .tag    (pipe_tag[p]),
                .par    (pipe_par[p]),
                .res    (res[p])
            );
            assign err_v[p] = res[p].err;
            assign unc_v[p] = res[p].uncorr;
        end
    endgenerate

    tpg_status #(.VA_W(VA_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .err      (err_v),
        .uncorr   (unc_v),
        .va       (pipe_va),
        .clr_stat (clr_stat),
        .clr_va   (clr_va),
        .stat_q   (err_stat),
        .va_q     (err_va),
        .uncorr_q (err_uncorr)
    );

    tpg_mchk u_mchk (
        .clk       (clk),
        .rst       (rst),
        .new_err   (|err_v),
        .mchk_en   (mchk_en),
        .priv_mode (priv_mode),
        .req       (mchk_req)
    );

    // R2: disabled checking never raises a status bit
    a_r2_no_status_off: assert property (@(posedge clk) disable iff (rst)
        !chk_en |=> !$rose(|err_stat));

endmodule

// File: tb/tag_parity_guard_tb_top.sv
module tag_parity_guard_tb_top;
    localparam int TW = 4;
    localparam int VW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chk_en = 1'b0, mchk_en = 1'b0, priv_mode = 1'b0, clr_va = 1'b0;
    logic [1:0] pipe_vld = '0, pipe_retry = '0, pipe_par = '0, clr_stat = '0;
    logic [1:0][TW-1:0] pipe_tag = '0;
    logic [1:0][VW-1:0] pipe_va = '0;
    logic [1:0] err_stat;
    logic [VW-1:0] err_va;
    logic err_uncorr, mchk_req;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tag_parity_guard #(.TAG_W(TW), .VA_W(VW)) dut_i (
        .clk(clk), .rst(rst), .chk_en(chk_en), .mchk_en(mchk_en),
        .priv_mode(priv_mode), .pipe_vld(pipe_vld), .pipe_retry(pipe_retry),
        .pipe_tag(pipe_tag), .pipe_par(pipe_par), .pipe_va(pipe_va),
        .clr_stat(clr_stat), .clr_va(clr_va), .err_stat(err_stat),
        .err_va(err_va), .err_uncorr(err_uncorr), .mchk_req(mchk_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        pipe_vld = '0; pipe_retry = '0; clr_stat = '0; clr_va = 1'b0;
    endtask

    task automatic clear_all();
        idle();
        clr_stat = 2'b11; clr_va = 1'b1;
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3 reset status", err_stat, 0);
        chk("R5 reset va", err_va, 0);
        chk("R6 reset uncorr", err_uncorr, 0);
        chk("R8 reset req", mchk_req, 0);

        // Sweep: each pipe, every tag/parity pair
        chk_en = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 32; v++) begin
                logic bad;
                logic [VW-1:0] va;
                bad = ^v[4:0];
                va = VW'(8'h40 + v + p * 8'h80);
                idle();
                pipe_vld[p] = 1'b1;
                pipe_tag[p] = v[4:1];
                pipe_par[p] = v[0];
                pipe_retry[p] = v[1];
                pipe_va[p] = va;
                mchk_en = v[2];
                @(negedge clk);
                chk("R1 R3 sweep status", err_stat, bad ? (32'd1 << p) : 0);
                chk("R4 sweep va", err_va, bad ? va : 0);
                chk("R6 sweep uncorr", err_uncorr, bad & v[1]);
                chk("R7 sweep req", mchk_req, bad & v[2]);
                clear_all();
                chk("R3 R8 after clear", {err_stat, mchk_req}, 0);
                chk("R5 R6 after clear", {err_va, err_uncorr}, 0);
            end
        end

        // R2: checking disabled
        chk_en = 1'b0; mchk_en = 1'b1;
        pipe_vld = 2'b01; pipe_tag[0] = 4'b0001; pipe_par[0] = 1'b0;
        pipe_retry = 2'b01; pipe_va[0] = 8'h5A;
        @(negedge clk);
        idle();
        chk("R2 off status", err_stat, 0);
        chk("R2 off va", err_va, 0);
        chk("R2 off uncorr", err_uncorr, 0);
        chk("R2 off req", mchk_req, 0);
        chk_en = 1'b1; mchk_en = 1'b0;

        // R4: both pipes fail together
        pipe_vld = 2'b11;
        pipe_tag[0] = 4'b0011; pipe_par[0] = 1'b1; pipe_va[0] = 8'h11;
        pipe_tag[1] = 4'b0111; pipe_par[1] = 1'b0; pipe_va[1] = 8'h22;
        @(negedge clk);
        idle();
        chk("R4 both status", err_stat, 2'b11);
        chk("R4 both va pipe0", err_va, 8'h11);

        // R5: locked, new pipe1 error does not move address
        pipe_vld = 2'b10; pipe_va[1] = 8'h33;
        @(negedge clk);
        idle();
        chk("R5 locked va", err_va, 8'h11);

        // R3: partial clear
        clr_stat = 2'b01;
        @(negedge clk);
        idle();
        chk("R3 partial clear", err_stat, 2'b10);
        chk("R5 va kept", err_va, 8'h11);

        // R5: address clear while locked
        clr_va = 1'b1;
        @(negedge clk);
        idle();
        chk("R5 va clear", err_va, 0);

        // R3: set beats clear
        clr_stat = 2'b10; pipe_vld = 2'b10;
        @(negedge clk);
        idle();
        chk("R3 set wins", err_stat, 2'b10);
        chk("R5 no capture locked", err_va, 0);
        clear_all();

        // R8: held while privileged
        priv_mode = 1'b1; mchk_en = 1'b1;
        pipe_vld = 2'b01; pipe_tag[0] = 4'b0001; pipe_par[0] = 1'b0; pipe_va[0] = 8'h77;
        @(negedge clk);
        idle(); mchk_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R8 held in priv", mchk_req, 0);
            @(negedge clk);
        end
        priv_mode = 1'b0;
        #1;
        chk("R8 released", mchk_req, 1);
        @(negedge clk);
        chk("R8 one cycle", mchk_req, 0);
        @(negedge clk);
        chk("R8 stays clear", mchk_req, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule